// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block is the bus-facing front end of a small-page NAND flash device model. An 8-bit I/O bus is sampled on a one-cycle write strobe, and four control inputs qualify each byte: command latch enable, address latch enable, active-low chip enable and active-low write protect. A byte written with the command latch high is decoded as a command. A byte written with the address latch high is stored in a multi-byte address register. Any other byte written during a program is pushed to a page buffer that sits outside the block.

The sequencer decides when an operation has received enough bytes to begin. At that point it sends a one-cycle start pulse to a storage engine, together with the page address and the starting column. On the read side it returns the identification bytes, the status byte or bytes from the array. It returns 0x00 when no data is pending. The memory array, the page buffer and bad-block handling are outside this block.

Top module: `nand_cmd_seq`

## Requirements
- R1: A byte is taken as a command only on a cycle with we_i=1, ce_ni=0 and cle_i=1. A byte is taken as an address only when we_i=1, ce_ni=0, ale_i=1 and cle_i=0. Writes with ce_ni=1 have no effect.
- R2: Command 0x00 sets the column offset to 0, command 0x01 sets it to 0x100 and command 0x50 sets it to PAGE_BYTES (512). All three then act as the 0x00 read. col_o equals address byte 0 plus the offset.
- R3: Address byte n goes to addr_o bits [8n+7:8n], where n is the number of address bytes received since the last command. Once ADDR_BYTES (4) bytes have arrived, further bytes are dropped. Every command sets n back to 0.
- R4: After command 0x90, the first address byte arms the identification sequence. Reads then return MFR_ID, DEV_ID, FILL_ID and 0xC0, followed by 0x00.
- R5: For command 0x00, the third address byte causes a one-cycle rd_start_o in the cycle after the write. Reads then return rd_data_i with rd_pop_o=1 for 528-col_o bytes, or for none if col_o exceeds 528, and return 0x00 after that.
- R6: For command 0x80, the third address byte causes a one-cycle prog_open_o. After that, data bytes (cle_i=0, ale_i=0) appear on wr_data_o with wr_push_o=1, up to 528 bytes.
- R7: Command 0x10 causes prog_go_o, and command 0xD0 causes erase_go_o, one cycle after the write, but only when wp_ni=1. When wp_ni=0 neither pulse appears. The start pulses are never active together.
- R8: On command 0xD0 the address is reduced to the bytes received since the last command and shifted up by one byte, so that addr_o[7:0]=0 while erase_go_o is high.
- R9: After command 0x70, every read returns the status byte without popping or advancing, until another legal command is written.
- R10: Status bit 7 equals wp_ni, bit 6 is 1 (ready), bit 0 is a sticky error set by engine_fail_i, and bits 5:1 are 0.
- R11: Command 0xFF and rst_ni restore the command to the 0x00 read and clear the address, the address count, the pending data length, the offset and the error bit.
- R12: An unrecognised command byte causes a one-cycle illegal_cmd_o, clears the address count and leaves the read mode unchanged.
- R13: While ce_ni=1, io_o is 0x00 and reads consume nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| wp_ni | input | 1 | Write protect, active low |
| we_i | input | 1 | One-cycle write strobe for io_i |
| io_i | input | 8 | Bus byte written in |
| re_i | input | 1 | One-cycle read strobe; consumes io_o |
| io_o | output | 8 | Byte a read returns |
| rd_data_i | input | 8 | Array byte from the storage engine |
| rd_pop_o | output | 1 | Array byte consumed |
| wr_push_o | output | 1 | Program data byte valid |
| wr_data_o | output | 8 | Program data byte |
| engine_fail_i | input | 1 | Engine reports a failed operation |
| addr_o | output | 32 | Assembled address |
| col_o | output | 10 | Start column (address byte 0 plus offset) |
| rd_start_o | output | 1 | Page read start pulse |
| prog_open_o | output | 1 | Program load start pulse |
| prog_go_o | output | 1 | Program commit pulse |
| erase_go_o | output | 1 | Block erase pulse |
| illegal_cmd_o | output | 1 | Unknown command pulse |

## Verification
The start pulses, the illegal-command flag and the address register are due one clock after the write strobe that triggers them. The bench therefore samples them at the falling edge that ends the strobe cycle. io_o, rd_pop_o and wr_push_o are combinational with respect to the current strobe. The bench samples them at the falling edge, before it raises re_i, and shortly after it drives we_i. The bench counts pushes and pops and checks that any further read shows 0x00, which proves that a data window has closed.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [7:0] CMD_RD_A    = 8'h00;
  localparam logic [7:0] CMD_RD_B    = 8'h01;
  localparam logic [7:0] CMD_RD_C    = 8'h50;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STAT    = 8'h70;
  localparam logic [7:0] CMD_PRG_SET = 8'h80;
  localparam logic [7:0] CMD_PRG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERS_SET = 8'h60;
  localparam logic [7:0] CMD_ERS_GO  = 8'hD0;
  localparam logic [7:0] CMD_RST     = 8'hFF;
  localparam logic [7:0] ID_TAIL     = 8'hC0;

  typedef enum logic [3:0] {
    OP_READ, OP_IDENT, OP_STAT, OP_PRG_SET, OP_PRG_GO,
    OP_ERS_SET, OP_ERS_GO, OP_RST, OP_BAD
  } op_e;

  typedef enum logic [1:0] {OFF_KEEP, OFF_ZERO, OFF_HALF, OFF_PAGE} off_sel_e;

  typedef enum logic [1:0] {RM_NONE, RM_IDENT, RM_STAT, RM_ARRAY} rd_mode_e;
endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_seq_pkg::*;
(
  input  logic [7:0] byte_i,
  output op_e        op_o,
  output off_sel_e   off_sel_o
);
  always_comb begin
    off_sel_o = OFF_KEEP;
    unique case (byte_i)
      CMD_RD_A:    begin op_o = OP_READ; off_sel_o = OFF_ZERO; end
      CMD_RD_B:    begin op_o = OP_READ; off_sel_o = OFF_HALF; end
      CMD_RD_C:    begin op_o = OP_READ; off_sel_o = OFF_PAGE; end
      CMD_IDENT:   op_o = OP_IDENT;
      CMD_STAT:    op_o = OP_STAT;
      CMD_PRG_SET: op_o = OP_PRG_SET;
      CMD_PRG_GO:  op_o = OP_PRG_GO;
      CMD_ERS_SET: op_o = OP_ERS_SET;
      CMD_ERS_GO:  op_o = OP_ERS_GO;
      CMD_RST:     op_o = OP_RST;
      default:     op_o = OP_BAD;
    endcase
  end
endmodule

// File: rtl/nand_addr_acc.sv
module nand_addr_acc #(
  parameter int NBYTES = 4,
  parameter int CNT_W  = $clog2(NBYTES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 soft_rst_i,
  input  logic                 clr_i,
  input  logic                 fix_i,
  input  logic                 load_i,
  input  logic [7:0]           byte_i,
  output logic [8*NBYTES-1:0]  addr_o,
  output logic [CNT_W-1:0]     cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       lane_q [NBYTES];

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          lane_q[k] <= '0;
      else if (soft_rst_i)  lane_q[k] <= '0;
      else if (fix_i) begin
        // erase: keep received bytes only, move up one lane
        if (k == 0)                     lane_q[k] <= '0;
        else if ((k - 1) < int'(cnt_q)) lane_q[k] <= lane_q[(k == 0) ? 0 : k - 1];
        else                            lane_q[k] <= '0;
      end else if (load_i && int'(cnt_q) == k) lane_q[k] <= byte_i;
    end
    assign addr_o[8*k +: 8] = lane_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (soft_rst_i || clr_i)            cnt_q <= '0;
    else if (load_i && int'(cnt_q) < NBYTES) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && !soft_rst_i && int'(cnt_q) < NBYTES) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/nand_read_path.sv
module nand_read_path
  import nand_seq_pkg::*;
#(
  parameter int         LEN_W   = 10,
  parameter logic [7:0] MFR_ID  = 8'hEC,
  parameter logic [7:0] DEV_ID  = 8'h73,
  parameter logic [7:0] FILL_ID = 8'h5A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             clear_i,
  input  logic             start_id_i,
  input  logic             start_stat_i,
  input  logic             start_arr_i,
  input  logic [LEN_W-1:0] arr_len_i,
  input  logic             re_i,
  input  logic             ce_ni,
  input  logic [7:0]       status_i,
  input  logic [7:0]       rd_data_i,
  output logic [7:0]       io_o,
  output logic             rd_pop_o
);
  rd_mode_e         mode_q;
  logic [LEN_W-1:0] rem_q;
  logic             take;
  logic [7:0]       id_byte;

  assign take = re_i && !ce_ni && (rem_q != '0) &&
                (mode_q == RM_IDENT || mode_q == RM_ARRAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RM_NONE;
      rem_q  <= '0;
    end else if (soft_rst_i) begin
      mode_q <= RM_NONE;
      rem_q  <= '0;
    end else if (start_id_i) begin
      mode_q <= RM_IDENT;
      rem_q  <= LEN_W'(4);
    end else if (start_stat_i) begin
      mode_q <= RM_STAT;
      rem_q  <= '0;
    end else if (start_arr_i) begin
      mode_q <= RM_ARRAY;
      rem_q  <= arr_len_i;
    end else if (clear_i) begin
      mode_q <= RM_NONE;
      rem_q  <= '0;
    end else if (take) begin
      rem_q  <= rem_q - 1'b1;
    end
  end

  always_comb begin
    unique case (rem_q[2:0])
      3'd4:    id_byte = MFR_ID;
      3'd3:    id_byte = DEV_ID;
      3'd2:    id_byte = FILL_ID;
      3'd1:    id_byte = ID_TAIL;
      default: id_byte = 8'h00;
    endcase
  end

  always_comb begin
    io_o = 8'h00;
    if (!ce_ni) begin
      unique case (mode_q)
        RM_STAT:  io_o = status_i;
        RM_IDENT: io_o = (rem_q != '0) ? id_byte : 8'h00;
        RM_ARRAY: io_o = (rem_q != '0) ? rd_data_i : 8'h00;
        default:  io_o = 8'h00;
      endcase
    end
  end

  assign rd_pop_o = take && (mode_q == RM_ARRAY);

  // R13
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !soft_rst_i && !clear_i && !start_id_i && !start_arr_i && !start_stat_i)
      |=> (rem_q == $past(rem_q)));
  // R9
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == RM_STAT) |-> !rd_pop_o);
  // R5
  pop_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_o |-> (io_o == rd_data_i));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int         PAGE_BYTES  = 512,
  parameter int         ADDR_BYTES  = 4,
  parameter int         START_BYTES = 3,
  parameter logic [7:0] MFR_ID      = 8'hEC,
  parameter logic [7:0] DEV_ID      = 8'h73,
  parameter logic [7:0] FILL_ID     = 8'h5A
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              ce_ni,
  input  logic                              cle_i,
  input  logic                              ale_i,
  input  logic                              wp_ni,
  input  logic                              we_i,
  input  logic [7:0]                        io_i,
  input  logic                              re_i,
  output logic [7:0]                        io_o,
  input  logic [7:0]                        rd_data_i,
  output logic                              rd_pop_o,
  output logic                              wr_push_o,
  output logic [7:0]                        wr_data_o,
  input  logic                              engine_fail_i,
  output logic [8*ADDR_BYTES-1:0]           addr_o,
  output logic [$clog2(PAGE_BYTES+256)-1:0] col_o,
  output logic                              rd_start_o,
  output logic                              prog_open_o,
  output logic                              prog_go_o,
  output logic                              erase_go_o,
  output logic                              illegal_cmd_o
);
  localparam int OOB_BYTES = PAGE_BYTES / 32;
  localparam int TOTAL     = PAGE_BYTES + OOB_BYTES;
  localparam int COL_W     = $clog2(PAGE_BYTES + 256);
  localparam int LEN_W     = $clog2(TOTAL + 1);
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1);

  logic             cmd_we, addr_we, data_we;
  op_e              op, cmd_q;
  off_sel_e         off_sel;
  logic [COL_W-1:0] off_q, col_w;
  logic [LEN_W-1:0] arr_len, prog_len_q;
  logic [CNT_W-1:0] cnt;
  logic             err_q, prog_armed_q, soft_rst;
  logic             id_go, rd_go, pr_go, rd_clear;
  logic [7:0]       status_w;

  assign cmd_we  = we_i && !ce_ni && cle_i;
  assign addr_we = we_i && !ce_ni && ale_i && !cle_i;
  assign data_we = we_i && !ce_ni && !ale_i && !cle_i;

  nand_cmd_decode u_dec (.byte_i(io_i), .op_o(op), .off_sel_o(off_sel));

  assign soft_rst = cmd_we && (op == OP_RST);
  assign rd_clear = cmd_we && (op != OP_STAT) && (op != OP_BAD);

  nand_addr_acc #(.NBYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_addr (
    .clk_i, .rst_ni,
    .soft_rst_i (soft_rst),
    .clr_i      (cmd_we),
    .fix_i      (cmd_we && op == OP_ERS_GO),
    .load_i     (addr_we),
    .byte_i     (io_i),
    .addr_o     (addr_o),
    .cnt_o      (cnt)
  );

  // Triggers on the address byte that completes each operation
  assign id_go = addr_we && cmd_q == OP_IDENT && cnt == '0;
  assign rd_go = addr_we && cmd_q == OP_READ && int'(cnt) == START_BYTES - 1;
  assign pr_go = addr_we && cmd_q == OP_PRG_SET && int'(cnt) == START_BYTES - 1;

  assign col_w   = {{(COL_W-8){1'b0}}, addr_o[7:0]} + off_q;
  assign arr_len = (int'(col_w) <= TOTAL) ? LEN_W'(TOTAL) - LEN_W'(col_w) : '0;
  assign col_o   = col_w;

  assign status_w = {wp_ni, 1'b1, 5'b0, err_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= OP_READ;
      off_q <= '0;
      err_q <= 1'b0;
    end else if (soft_rst) begin
      cmd_q <= OP_READ;
      off_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= op;
      if (cmd_we) begin
        unique case (off_sel)
          OFF_ZERO: off_q <= '0;
          OFF_HALF: off_q <= COL_W'(256);
          OFF_PAGE: off_q <= COL_W'(PAGE_BYTES);
          default:  off_q <= off_q;
        endcase
      end
      if (engine_fail_i) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_start_o    <= 1'b0;
      prog_open_o   <= 1'b0;
      prog_go_o     <= 1'b0;
      erase_go_o    <= 1'b0;
      illegal_cmd_o <= 1'b0;
    end else begin
      rd_start_o    <= rd_go;
      prog_open_o   <= pr_go;
      prog_go_o     <= cmd_we && op == OP_PRG_GO && wp_ni;
      erase_go_o    <= cmd_we && op == OP_ERS_GO && wp_ni;
      illegal_cmd_o <= cmd_we && op == OP_BAD;
    end
  end

  // Program data window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_armed_q <= 1'b0;
      prog_len_q   <= '0;
    end else if (rd_clear) begin
      prog_armed_q <= 1'b0;
      prog_len_q   <= '0;
    end else if (pr_go) begin
      prog_armed_q <= 1'b1;
      prog_len_q   <= '0;
    end else if (wr_push_o) begin
      prog_len_q   <= prog_len_q + 1'b1;
    end
  end

  assign wr_push_o = data_we && prog_armed_q && cmd_q == OP_PRG_SET &&
                     int'(prog_len_q) < TOTAL;
  assign wr_data_o = io_i;

  nand_read_path #(
    .LEN_W(LEN_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .FILL_ID(FILL_ID)
  ) u_rd (
    .clk_i, .rst_ni,
    .soft_rst_i   (soft_rst),
    .clear_i      (rd_clear),
    .start_id_i   (id_go),
    .start_stat_i (cmd_we && op == OP_STAT),
    .start_arr_i  (rd_go),
    .arr_len_i    (arr_len),
    .re_i, .ce_ni,
    .status_i     (status_w),
    .rd_data_i,
    .io_o,
    .rd_pop_o
  );

  // R7
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_start_o, prog_open_o, prog_go_o, erase_go_o, illegal_cmd_o}));
  // R7
  wp_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_go_o || erase_go_o) |-> $past(wp_ni));
  // R8
  erase_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go_o |-> (addr_o[7:0] == 8'h00));
  // R6
  push_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_push_o |-> (int'(prog_len_q) < TOTAL));
  // R12
  illegal_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_cmd_o |-> (cnt == '0));
endmodule

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;
  localparam int CLK_NS = 20;
  localparam int TOTAL  = 528;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, wp_n = 1'b1, we = 1'b0, re = 1'b0;
  logic [7:0] io_in = 8'h00, rd_data = 8'h00;
  logic fail_in = 1'b0;
  logic [7:0] io_out, wr_data;
  logic rd_pop, wr_push, rd_start, prog_open, prog_go, erase_go, illegal;
  logic [31:0] addr;
  logic [9:0] col;

  int checks = 0, failures = 0, pushes = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  nand_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .wp_ni(wp_n), .we_i(we), .io_i(io_in), .re_i(re), .io_o(io_out),
    .rd_data_i(rd_data), .rd_pop_o(rd_pop), .wr_push_o(wr_push),
    .wr_data_o(wr_data), .engine_fail_i(fail_in), .addr_o(addr), .col_o(col),
    .rd_start_o(rd_start), .prog_open_o(prog_open), .prog_go_o(prog_go),
    .erase_go_o(erase_go), .illegal_cmd_o(illegal)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; io_in = b; we = 1'b1;
    #1;
    if (wr_push) pushes++;
    @(negedge clk);
    we = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b); wr(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b); wr(1'b0, 1'b1, b); endtask

  task automatic rd(output logic [7:0] v, output logic pop);
    @(negedge clk);
    v = io_out; re = 1'b1;
    #1 pop = rd_pop;
    @(negedge clk);
    re = 1'b0;
  endtask

  function automatic int exp_col(input int v, input logic [7:0] b0);
    return int'(b0) + ((v == 0) ? 0 : (v == 1) ? 256 : 512);
  endfunction

  function automatic int exp_len(input int c);
    return (c <= TOTAL) ? TOTAL - c : 0;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b0, b1, b2;
    logic p;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(io_out == 8'h00 && addr == 0, "R11 reset io/addr", {io_out, addr}, 0);
    chk({rd_start, prog_open, prog_go, erase_go, illegal} == 0, "R11 reset pulses",
        {rd_start, prog_open, prog_go, erase_go, illegal}, 0);

    // R4 identification, with R13 CE-high read in the middle
    cmd(8'h90); adr(8'h00);
    rd(v, p); chk(v == 8'hEC, "R4 mfr", v, 8'hEC);
    ce_n = 1'b1;
    rd(v, p); chk(v == 8'h00, "R13 ce high read", v, 0);
    ce_n = 1'b0;
    rd(v, p); chk(v == 8'h73, "R4 dev", v, 8'h73);
    rd(v, p); chk(v == 8'h5A, "R4 fill", v, 8'h5A);
    rd(v, p); chk(v == 8'hC0, "R4 tail", v, 8'hC0);
    rd(v, p); chk(v == 8'h00, "R4 exhausted", v, 0);

    // R1 command ignored with CE high
    ce_n = 1'b1; cmd(8'h70); ce_n = 1'b0;
    rd(v, p); chk(v == 8'h00, "R1 ce high cmd ignored", v, 0);

    // R9 R10 status
    cmd(8'h70);
    for (int k = 0; k < 3; k++) begin
      rd(v, p);
      chk(v == 8'hC0 && !p, "R9 status repeat", {p, v}, 8'hC0);
    end
    wp_n = 1'b0; @(negedge clk);
    rd(v, p); chk(v == 8'h40, "R10 wp low bit7", v, 8'h40);
    wp_n = 1'b1;
    @(negedge clk); fail_in = 1'b1; @(negedge clk); fail_in = 1'b0;
    rd(v, p); chk(v == 8'hC1, "R10 error bit", v, 8'hC1);

    // R11 reset command
    cmd(8'h00); adr(8'h12); adr(8'h34);
    cmd(8'hFF);
    chk(addr == 0, "R11 addr cleared", addr, 0);
    cmd(8'h70);
    rd(v, p); chk(v == 8'hC0, "R11 error cleared", v, 8'hC0);

    // R2 R3 R5 random reads
    for (int it = 0; it < 24; it++) begin
      int var_sel, c, n;
      var_sel = $urandom_range(0, 2);
      b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
      rd_data = 8'h3C ^ 8'(it);
      cmd(var_sel == 0 ? 8'h00 : var_sel == 1 ? 8'h01 : 8'h50);
      adr(b0); adr(b1);
      chk(!rd_start, "R5 no early start", rd_start, 0);
      adr(b2);
      c = exp_col(var_sel, b0);
      n = exp_len(c);
      chk(rd_start, "R5 start on third byte", rd_start, 1);
      chk(addr[23:0] == {b2, b1, b0}, "R3 little endian", addr[23:0], {b2, b1, b0});
      chk(int'(col) == c, "R2 column offset", col, c);
      for (int k = 0; k < 3; k++) begin
        rd(v, p);
        if (k < n) chk(v == rd_data && p, "R5 array data", {p, v}, {1'b1, rd_data});
        else chk(v == 8'h00 && !p, "R5 past end", {p, v}, 0);
      end
    end

    // R5 boundary: col 522 gives 6 bytes
    rd_data = 8'hA7;
    cmd(8'h50); adr(8'd10); adr(8'h01); adr(8'h00);
    chk(col == 10'd522, "R2 page offset", col, 522);
    for (int k = 0; k < 7; k++) begin
      rd(v, p);
      if (k < 6) chk(v == 8'hA7 && p, "R5 tail bytes", {p, v}, 9'h1A7);
      else chk(v == 8'h00 && !p, "R5 window closed", {p, v}, 0);
    end
    cmd(8'h50); adr(8'd20); adr(8'h01); adr(8'h00);
    rd(v, p); chk(v == 8'h00 && !p, "R5 column beyond spare", {p, v}, 0);

    // R3 saturation and count clear
    cmd(8'h00); adr(8'h11); adr(8'h22); adr(8'h33); adr(8'h44); adr(8'h55);
    chk(addr == 32'h44332211, "R3 fifth byte dropped", addr, 32'h44332211);
    cmd(8'h00); adr(8'hBB);
    chk(addr == 32'h443322BB, "R3 count cleared by command", addr, 32'h443322BB);

    // R6 program load
    cmd(8'h80); adr(8'h05); adr(8'h01);
    chk(!prog_open, "R6 no early open", prog_open, 0);
    adr(8'h00);
    chk(prog_open, "R6 open pulse", prog_open, 1);
    pushes = 0;
    @(negedge clk); cle = 1'b0; ale = 1'b0; io_in = 8'h6D; we = 1'b1;
    #1 chk(wr_push && wr_data == 8'h6D, "R6 data push", {wr_push, wr_data}, 9'h16D);
    @(negedge clk); we = 1'b0;
    pushes = 1;
    for (int k = 0; k < 529; k++) wr(1'b0, 1'b0, 8'(k));
    chk(pushes == TOTAL, "R6 push limit", pushes, TOTAL);

    // R7 confirm gating
    cmd(8'h10); chk(prog_go, "R7 program go", prog_go, 1);
    wp_n = 1'b0; cmd(8'h10); chk(!prog_go, "R7 program blocked", prog_go, 0);
    cmd(8'h60); cmd(8'hD0); chk(!erase_go, "R7 erase blocked", erase_go, 0);
    wp_n = 1'b1;

    // R8 erase address
    cmd(8'h60); adr(8'h34); adr(8'h12); cmd(8'hD0);
    chk(erase_go && addr == 32'h00123400, "R8 erase two bytes", addr, 32'h00123400);
    cmd(8'h60); adr(8'h56); adr(8'h34); adr(8'h12); cmd(8'hD0);
    chk(erase_go && addr == 32'h12345600, "R8 erase three bytes", addr, 32'h12345600);

    // R12 illegal command
    cmd(8'h70); chk(!illegal, "R12 legal no flag", illegal, 0);
    adr(8'h99);
    cmd(8'hAB); chk(illegal, "R12 flag", illegal, 1);
    @(negedge clk); chk(!illegal, "R12 one cycle", illegal, 0);
    rd(v, p); chk(v == 8'hC0, "R12 read mode kept", v, 8'hC0);
    adr(8'h77); chk(addr[7:0] == 8'h77, "R12 count cleared", addr[7:0], 8'h77);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule